// File: doc/BRIEF.md
# Configurable Add/Multiply Compute Unit

This block is one coarse-grain compute tile of a virtual reconfigurable fabric built on top of an FPGA. It receives two fixed-point operands from the routing network, optionally delays each of them by a programmable number of cycles, and applies either an addition or a multiplication. The result is captured in an output register. The per-input delays let operands that arrive over routes of different pipeline depth meet at the operator in the same cycle.

All settings sit in a serial configuration chain. A 7-bit word is clocked in one bit per cycle while the shift enable is high. The chain's last flop drives a serial output, so several tiles can be chained into one long configuration stream. While shifting is under way the result register keeps its value. The new setting governs the first clock edge after shifting stops.

Top module: `cu_addmul`

## Requirements
- R1: When the operation bit is 0, the result equals (aligned A + aligned B) modulo 2^16.
- R2: When the operation bit is 1, the result equals the low 16 bits of the product of aligned A and aligned B.
- R3: Operand A is delayed by `delay_a` cycles (0 to 7). An operand sampled at clock edge n affects the result that is visible after edge n + delay_a. A delay of 0 feeds `a_in` straight to the operator.
- R4: Operand B is delayed by `delay_b` cycles (0 to 7). This delay is set independently of operand A, with the same timing rule as R3.
- R5: While `cfg_en` is high, each clock edge shifts `cfg_in` into a 7-bit chain, most significant bit first. The first bit shifted in becomes the operation bit (bit 6). The next three bits become `delay_a` (bits 5:4:3, MSB first). The last three bits become `delay_b` (bits 2:0, MSB first).
- R6: `cfg_out` shows chain bit 6. After j shifts with j ≥ 7, it carries the bit that was shifted in at shift j−6. It does not change while `cfg_en` is low.
- R7: While `cfg_en` is high, `y_out` keeps its value whatever the operands do.
- R8: After reset, `y_out` is 0 and `cfg_out` is 0. The reset configuration is add with both delays 0.
- R9: A newly shifted configuration controls the first clock edge at which `cfg_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Shift enable for the configuration chain; holds the result while high |
| cfg_in | input | 1 | Serial configuration bit in |
| cfg_out | output | 1 | Serial configuration bit out, to the next tile |
| a_in | input | 16 | Operand A from the routing network |
| b_in | input | 16 | Operand B from the routing network |
| y_out | output | 16 | Registered result |

## Verification
The bench builds the unit with its default parameters: a 16-bit data width and 3-bit delay fields. This makes the full delay range of 0 to 7 cycles reachable on both inputs, along with 16-bit wraparound of the sum and truncation of the product. Streams of operands that change every cycle are used to tell one delay setting from another. The vector table covers the overflow cases with operands held steady. Directed sequences cover the result hold during shifting, the switch-over cycle when shifting stops, and the serial output of a 14-bit stream.

// File: rtl/cu_addmul_pkg.sv
package cu_addmul_pkg;

  // Operation selected by the top bit of the configuration word.
  typedef enum logic {
    CU_OP_ADD = 1'b0,
    CU_OP_MUL = 1'b1
  } cu_op_e;

  localparam int CU_OP_BITS = 1;

endpackage

// File: rtl/cu_cfg_chain.sv
module cu_cfg_chain #(
  parameter int CFG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             ser_in,
  output logic             ser_out,
  output logic [CFG_W-1:0] word
);

  logic [CFG_W-1:0] chain_q;

  // MSB-first load: the earliest bit travels up to the top position.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else if (shift_en) begin
      chain_q <= {chain_q[CFG_W-2:0], ser_in};
    end
  end

  assign word    = chain_q;
  assign ser_out = chain_q[CFG_W-1];

endmodule

// File: rtl/cu_delay_line.sv
module cu_delay_line #(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  localparam int DEPTH = (1 << SEL_W) - 1;

  // taps[k] is din delayed by k cycles; taps[0] is the input itself.
  logic [DATA_W-1:0] taps [0:DEPTH];

  assign taps[0] = din;

  for (genvar k = 1; k <= DEPTH; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        taps[k] <= '0;
      end else begin
        taps[k] <= taps[k-1];
      end
    end
  end

  assign dout = taps[sel];

endmodule

// File: rtl/cu_alu.sv
module cu_alu
  import cu_addmul_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  cu_op_e            op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);

  function automatic logic [DATA_W-1:0] f_add(input logic [DATA_W-1:0] x,
                                              input logic [DATA_W-1:0] z);
    return x + z;
  endfunction

  function automatic logic [DATA_W-1:0] f_mul(input logic [DATA_W-1:0] x,
                                              input logic [DATA_W-1:0] z);
    logic [2*DATA_W-1:0] full;
    full = x * z;
    return full[DATA_W-1:0];
  endfunction

  logic [DATA_W-1:0] y_d;
  logic [DATA_W-1:0] y_q;

  always_comb begin
    case (op)
      CU_OP_MUL: y_d = f_mul(a, b);
      default:   y_d = f_add(a, b);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q <= '0;
    end else if (!hold) begin
      y_q <= y_d;
    end
  end

  assign y = y_q;

endmodule

// File: rtl/cu_addmul.sv
module cu_addmul
  import cu_addmul_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DLY_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_in,
  output logic              cfg_out,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  output logic [DATA_W-1:0] y_out
);

  localparam int CFG_W = CU_OP_BITS + 2 * DLY_W;

  logic [CFG_W-1:0]  cfg_word;
  cu_op_e            op_sel_w;
  logic [DLY_W-1:0]  dly_a_w;
  logic [DLY_W-1:0]  dly_b_w;
  logic [DATA_W-1:0] a_aligned;
  logic [DATA_W-1:0] b_aligned;

  cu_cfg_chain #(.CFG_W(CFG_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_en),
    .ser_in   (cfg_in),
    .ser_out  (cfg_out),
    .word     (cfg_word)
  );

  // Field positions: op on top, then delay A, then delay B.
  assign op_sel_w = cu_op_e'(cfg_word[CFG_W-1]);
  assign dly_a_w  = cfg_word[2*DLY_W-1:DLY_W];
  assign dly_b_w  = cfg_word[DLY_W-1:0];

  cu_delay_line #(.DATA_W(DATA_W), .SEL_W(DLY_W)) u_dly_a (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (dly_a_w),
    .din   (a_in),
    .dout  (a_aligned)
  );

  cu_delay_line #(.DATA_W(DATA_W), .SEL_W(DLY_W)) u_dly_b (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (dly_b_w),
    .din   (b_in),
    .dout  (b_aligned)
  );

  cu_alu #(.DATA_W(DATA_W)) u_alu (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (cfg_en),
    .op    (op_sel_w),
    .a     (a_aligned),
    .b     (b_aligned),
    .y     (y_out)
  );

endmodule

// File: rtl/cu_addmul_chk.sv
module cu_addmul_chk
  import cu_addmul_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DLY_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_en,
  input logic              cfg_out,
  input logic [DATA_W-1:0] a_in,
  input logic [DATA_W-1:0] b_in,
  input logic [DATA_W-1:0] y_out,
  input cu_op_e            op_sel_w,
  input logic [DLY_W-1:0]  dly_a_w,
  input logic [DLY_W-1:0]  dly_b_w,
  input logic [DATA_W-1:0] a_aligned,
  input logic [DATA_W-1:0] b_aligned
);

  logic [DATA_W-1:0] sum_lo;
  logic [DATA_W-1:0] prod_lo;

  assign sum_lo  = DATA_W'(a_aligned + b_aligned);
  assign prod_lo = DATA_W'(a_aligned * b_aligned);

  AST_HOLD_WHILE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> $stable(y_out)); // R7

  AST_ADD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && op_sel_w == CU_OP_ADD) |=> (y_out == $past(sum_lo))); // R1

  AST_MUL_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && op_sel_w == CU_OP_MUL) |=> (y_out == $past(prod_lo))); // R2

  AST_DELAY_A_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && dly_a_w == DLY_W'(1)) |-> (a_aligned == $past(a_in))); // R3

  AST_DELAY_B_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && dly_b_w == DLY_W'(1)) |-> (b_aligned == $past(b_in))); // R4

  AST_CHAIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(cfg_out)); // R6

endmodule

bind cu_addmul cu_addmul_chk #(.DATA_W(DATA_W), .DLY_W(DLY_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_en    (cfg_en),
  .cfg_out   (cfg_out),
  .a_in      (a_in),
  .b_in      (b_in),
  .y_out     (y_out),
  .op_sel_w  (op_sel_w),
  .dly_a_w   (dly_a_w),
  .dly_b_w   (dly_b_w),
  .a_aligned (a_aligned),
  .b_aligned (b_aligned)
);

// File: tb/cu_addmul_tb.sv
module cu_addmul_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b0;
  logic        cfg_in = 1'b0;
  logic        cfg_out;
  logic [15:0] a_in = '0;
  logic [15:0] b_in = '0;
  logic [15:0] y_out;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  cu_addmul u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_in(cfg_in),
    .cfg_out(cfg_out), .a_in(a_in), .b_in(b_in), .y_out(y_out)
  );

  // Row: op(1) delay_a(3) delay_b(3) a(16) b(16) expected(16)
  localparam logic [54:0] VEC [8] = '{
    {1'b0, 3'd0, 3'd0, 16'h0003, 16'h0004, 16'h0007},
    {1'b0, 3'd2, 3'd5, 16'hFFFF, 16'h0002, 16'h0001},
    {1'b1, 3'd1, 3'd0, 16'h0010, 16'h0010, 16'h0100},
    {1'b1, 3'd7, 3'd3, 16'h1234, 16'h0100, 16'h3400},
    {1'b1, 3'd4, 3'd4, 16'hFFFF, 16'hFFFF, 16'h0001},
    {1'b0, 3'd6, 3'd1, 16'h8000, 16'h8000, 16'h0000},
    {1'b1, 3'd0, 3'd7, 16'h0300, 16'h0300, 16'h0000},
    {1'b0, 3'd3, 3'd2, 16'h1234, 16'h4321, 16'h5555}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Shift a 7-bit word MSB first; returns at the negedge after the last shift.
  task automatic load_cfg(input logic op, input logic [2:0] da, input logic [2:0] db);
    logic [6:0] w;
    w = {op, da, db};
    for (int i = 6; i >= 0; i--) begin
      cfg_en = 1'b1;
      cfg_in = w[i];
      @(negedge clk);
    end
    cfg_en = 1'b0;
    cfg_in = 1'b0;
  endtask

  function automatic logic [15:0] ref_op(input logic op, input logic [15:0] x, input logic [15:0] z);
    logic [31:0] p;
    p = {16'h0, x} * {16'h0, z};
    return op ? p[15:0] : 16'(x + z);
  endfunction

  function automatic logic [15:0] stream_a(input int n);
    return 16'(n * 37 + 5);
  endfunction

  function automatic logic [15:0] stream_b(input int n);
    return 16'(n * 11 + 300);
  endfunction

  task automatic run_stream(input logic op, input logic [2:0] da, input logic [2:0] db, input string req);
    load_cfg(op, da, db);
    for (int n = 0; n < 30; n++) begin
      if (n >= 9)
        check(req, y_out, ref_op(op, stream_a(n - 1 - int'(da)), stream_b(n - 1 - int'(db))));
      a_in = stream_a(n);
      b_in = stream_b(n);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] held;
    logic [13:0] pat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state
    check("R8 y_out", y_out, 16'h0000);
    check("R8 cfg_out", {15'h0, cfg_out}, 16'h0000);
    a_in = 16'd9; b_in = 16'd4;
    @(negedge clk);
    check("R8 default add", y_out, 16'd13);

    // R1 R2: vector table with operands held steady
    foreach (VEC[i]) begin
      load_cfg(VEC[i][54], VEC[i][53:51], VEC[i][50:48]);
      a_in = VEC[i][47:32];
      b_in = VEC[i][31:16];
      repeat (9) @(negedge clk);
      check(VEC[i][54] ? "R2 table" : "R1 table", y_out, VEC[i][15:0]);
    end

    // R7 hold while shifting, R9 switch-over cycle
    held = y_out;
    a_in = 16'd5; b_in = 16'd6;
    load_cfg(1'b1, 3'd0, 3'd0);
    check("R7 hold during shift", y_out, held);
    @(negedge clk);
    check("R9 first cycle after cfg_en low", y_out, 16'd30);

    // R3 R4: delays on changing streams
    run_stream(1'b0, 3'd3, 3'd0, "R3 delay_a=3");
    run_stream(1'b1, 3'd0, 3'd7, "R4 delay_b=7");
    run_stream(1'b0, 3'd7, 3'd7, "R3 R4 both 7");
    run_stream(1'b1, 3'd5, 3'd2, "R3 R4 5/2");

    // R5 R6: serial output of a 14-bit pattern
    pat = 14'b10110011100101;
    for (int j = 1; j <= 14; j++) begin
      cfg_en = 1'b1;
      cfg_in = pat[14 - j];
      @(negedge clk);
      if (j >= 7)
        check("R6 cfg_out", {15'h0, cfg_out}, {15'h0, pat[14 - (j - 6)]});
    end
    cfg_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R6 cfg_out idle", {15'h0, cfg_out}, {15'h0, pat[6]});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule